// File: doc/BRIEF.md
# Time-Sampled Majority Glitch Filter

This block removes short transients from a single-bit input. The input is sampled on every rising edge of a fast clock into a register chain. Three points along that chain are read at once: the newest sample, the sample taken D periods earlier and the sample taken 2D periods earlier. The majority of these three bits is registered as the filtered output.

A transient of D samples or fewer can hold at most one of the three taps at any moment, so the vote outvotes it. A transient of D+1 samples or more covers two taps together and passes through. The spacing D can be set at run time. A larger D rejects wider transients, but it also adds delay from input to output.

A valid strobe goes high once every tap holds a sample taken under the current spacing. It goes low again after reset and after any change of spacing.

Top module: `glitch_vote_filter`

## Requirements
- R1: While reset is asserted (rst_ni low), filt_o and valid_o are 0, and every chain stage is cleared to 0, whatever raw_i does.
- R2: With effective spacing D, the value of filt_o after rising edge m equals the majority of raw_i as sampled at edges m-1, m-1-D and m-1-2D. Edges are counted from 1 at the first edge after reset, and samples from before that edge count as 0.
- R3: On a steady background, a transient of D samples or fewer never changes filt_o.
- R4: On a steady background, a transient of D+1 samples or more does appear on filt_o.
- R5: After reset, valid_o is 0 after each of the first 2D+1 edges and is 1 from edge 2D+2 onward, as long as the spacing does not change.
- R6: If the effective spacing at an edge differs from the one at the previous edge, valid_o goes to 0 after that edge. It returns to 1 after the (2D+2)-th edge, counting that edge as the first, with D the new spacing.
- R7: A space_i value of 0 is treated as spacing 1 for both the taps and the valid timing.
- R8: The largest setting, 15, puts the taps 0, 15 and 30 samples back. Transients of up to 15 samples are then rejected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling clock; all state updates on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raw_i | input | 1 | Unfiltered input, sampled every edge |
| space_i | input | SPACE_W (4) | Tap spacing D in sample periods, 0 read as 1 |
| filt_o | output | 1 | Registered majority of the three taps |
| valid_o | output | 1 | High when all three taps hold samples taken under the current spacing |

## Verification
A wrong chain stage shows up on filt_o as soon as it reaches the middle or far tap. That is at most 2D+1 edges after the sample entered, and the scoreboard catches it because it predicts every cycle from its own sample history. A stuck or mis-counted fill counter shows as valid_o rising one or more edges too early or too late. A change of spacing that is missed shows as valid_o staying high on the edge after the change. Glitch widths of exactly D and D+1 are driven on both backgrounds, so a tap placed one stage off changes filt_o within that same transient.

// File: rtl/glitch_vote_pkg.sv
package glitch_vote_pkg;

    // two-of-three vote
    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/gv_tap_chain.sv
module gv_tap_chain #(
    parameter int SPACE_W = 4,
    parameter int LEN     = 31,
    parameter int IDX_W   = 5
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               raw_i,
    input  logic [SPACE_W-1:0] spacing_i,
    output logic               tap_near_o,
    output logic               tap_mid_o,
    output logic               tap_far_o
);
    typedef struct packed {
        logic [LEN-1:0] line;
    } chain_t;

    chain_t c_d, c_q;
    logic [IDX_W-1:0] mid_idx;
    logic [IDX_W-1:0] far_idx;

    always_comb begin
        c_d = c_q;
        c_d.line[0] = raw_i;
        for (int k = 1; k < LEN; k++) begin
            c_d.line[k] = c_q.line[k-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) c_q <= '0;
        else         c_q <= c_d;
    end

    assign mid_idx    = IDX_W'(spacing_i);
    assign far_idx    = mid_idx << 1;
    assign tap_near_o = c_q.line[0];
    assign tap_mid_o  = c_q.line[mid_idx];
    assign tap_far_o  = c_q.line[far_idx];

    // R1: a reset cycle leaves every tap at 0
    p_taps_cleared_r1: assert property (@(posedge clk_i)
        !rst_ni |=> (!tap_near_o && !tap_mid_o && !tap_far_o) || !rst_ni);

endmodule

// File: rtl/gv_fill_tracker.sv
module gv_fill_tracker #(
    parameter int SPACE_W = 4,
    parameter int LEN     = 31,
    parameter int IDX_W   = 5
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [SPACE_W-1:0] spacing_i,
    output logic               valid_o
);
    localparam logic [IDX_W-1:0] CNT_SAT = IDX_W'(LEN);

    typedef struct packed {
        logic [SPACE_W-1:0] space;
        logic [IDX_W-1:0]   cnt;
        logic               valid;
    } fill_t;

    fill_t f_d, f_q;
    logic [IDX_W-1:0] need;
    logic             same;

    assign need = (IDX_W'(spacing_i) << 1) + IDX_W'(1);
    assign same = (spacing_i == f_q.space);

    always_comb begin
        f_d = f_q;
        f_d.space = spacing_i;
        if (!same) begin
            f_d.cnt   = IDX_W'(1);
            f_d.valid = 1'b0;
        end else begin
            f_d.valid = (f_q.cnt >= need);
            if (f_q.cnt != CNT_SAT) f_d.cnt = f_q.cnt + IDX_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) f_q <= '0;
        else         f_q <= f_d;
    end

    assign valid_o = f_q.valid;

    // R6: any spacing change is followed by a low strobe
    p_change_drops_valid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (spacing_i != $past(spacing_i)) |=> !valid_o);

    // R5: a raised strobe implies the chain is filled for the held spacing
    p_valid_filled_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> (f_q.cnt >= (IDX_W'(f_q.space) << 1) + IDX_W'(1)));

endmodule

// File: rtl/gv_vote_stage.sv
module gv_vote_stage (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tap_near_i,
    input  logic tap_mid_i,
    input  logic tap_far_i,
    output logic filt_o
);
    import glitch_vote_pkg::maj3;

    typedef struct packed {
        logic out;
    } vote_t;

    vote_t v_d, v_q;

    always_comb begin
        v_d = v_q;
        v_d.out = maj3(tap_near_i, tap_mid_i, tap_far_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) v_q <= '0;
        else         v_q <= v_d;
    end

    assign filt_o = v_q.out;

    // R2: two agreeing taps decide the next output
    p_near_mid_win_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tap_near_i == tap_mid_i) |=> (filt_o == $past(tap_near_i)));

    // R3: the older pair outvotes a lone disagreeing newest tap
    p_mid_far_win_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tap_mid_i == tap_far_i) |=> (filt_o == $past(tap_mid_i)));

endmodule

// File: rtl/glitch_vote_filter.sv
module glitch_vote_filter #(
    parameter int SPACE_W = 4
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               raw_i,
    input  logic [SPACE_W-1:0] space_i,
    output logic               filt_o,
    output logic               valid_o
);
    localparam int MAX_SPACE = (1 << SPACE_W) - 1;
    localparam int LEN       = 2 * MAX_SPACE + 1;
    localparam int IDX_W     = SPACE_W + 1;

    logic [SPACE_W-1:0] eff_space;
    logic               t_near, t_mid, t_far;

    // R7: a zero setting is read as the minimum spacing
    assign eff_space = (space_i == '0) ? SPACE_W'(1) : space_i;

    gv_tap_chain #(
        .SPACE_W (SPACE_W),
        .LEN     (LEN),
        .IDX_W   (IDX_W)
    ) chain_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .raw_i      (raw_i),
        .spacing_i  (eff_space),
        .tap_near_o (t_near),
        .tap_mid_o  (t_mid),
        .tap_far_o  (t_far)
    );

    gv_vote_stage vote_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tap_near_i (t_near),
        .tap_mid_i  (t_mid),
        .tap_far_i  (t_far),
        .filt_o     (filt_o)
    );

    gv_fill_tracker #(
        .SPACE_W (SPACE_W),
        .LEN     (LEN),
        .IDX_W   (IDX_W)
    ) fill_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .spacing_i (eff_space),
        .valid_o   (valid_o)
    );

    // R1: outputs read as cleared at every edge that sees reset
    p_reset_clear_r1: assert property (@(posedge clk_i)
        !rst_ni |-> (!filt_o && !valid_o));

endmodule

// File: tb/glitch_vote_filter_tb_top.sv
module glitch_vote_filter_tb_top;
    localparam int SW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b1;
    logic          raw = 1'b0;
    logic [SW-1:0] sp = SW'(3);
    logic          filt;
    logic          vld;

    always #5 clk = ~clk;

    glitch_vote_filter #(.SPACE_W(SW)) dut_i (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .raw_i   (raw),
        .space_i (sp),
        .filt_o  (filt),
        .valid_o (vld)
    );

    typedef struct {
        logic  f;
        logic  v;
        string tag;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fail = 0;
    logic hist[0:8191];
    int   edge_n = 0;
    int   prev_eff = 0;
    int   fill_cnt = 0;
    bit   done = 1'b0;

    function automatic logic vote3(input logic a, input logic b, input logic c);
        int s;
        s = int'(a) + int'(b) + int'(c);
        return (s >= 2);
    endfunction

    function automatic logic h(input int i);
        if (i < 1) return 1'b0;
        return hist[i];
    endfunction

    task automatic check(input logic af, input logic av, input logic ef, input logic ev,
                         input string tag);
        n_checks++;
        if (af !== ef || av !== ev) begin
            n_fail++;
            $display("FAIL %s: filt=%b valid=%b, expected filt=%b valid=%b (edge %0d)",
                     tag, af, av, ef, ev, edge_n);
        end
    endtask

    // driver: one sample per edge, expectation pushed to the scoreboard
    task automatic step(input logic r, input int s, input string tag);
        int   d;
        exp_t e;
        @(negedge clk);
        raw = r;
        sp  = SW'(s);
        d   = (s == 0) ? 1 : s;
        edge_n++;
        e.f = vote3(h(edge_n - 1), h(edge_n - 1 - d), h(edge_n - 1 - 2 * d));
        hist[edge_n] = r;
        if (d != prev_eff) begin
            e.v = 1'b0;
            fill_cnt = 1;
            prev_eff = d;
        end else begin
            e.v = (fill_cnt >= 2 * d + 1);
            if (fill_cnt < 31) fill_cnt++;
        end
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic glitch(input logic bg, input int width, input int s, input string tag);
        int d;
        d = (s == 0) ? 1 : s;
        repeat (2 * d + 4) step(bg, s, tag);
        repeat (width) step(~bg, s, tag);
        repeat (2 * d + 4) step(bg, s, tag);
    endtask

    // monitor: compare each produced result against the queue head
    always @(posedge clk) begin
        exp_t e;
        if (rst_n && q.size() > 0) begin
            #2;
            e = q.pop_front();
            check(filt, vld, e.f, e.v, e.tag);
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog (all requirements): run not finished, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        // R1: reset held with a high input
        raw = 1'b1;
        #3 rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check(filt, vld, 1'b0, 1'b0, "R1");
        @(posedge clk);
        #2 rst_n = 1'b1;

        // R5: fill timing after reset, D=3 -> valid from edge 8
        repeat (12) step(1'b1, 3, "R5");

        // R2: pseudo-random input under two spacings
        lfsr = 16'hACE1;
        for (int i = 0; i < 200; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0], 3, "R2");
        end
        for (int i = 0; i < 100; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[3], 2, "R2");
        end

        // R3 / R4: glitch widths around D=4 on both backgrounds
        for (int w = 1; w <= 4; w++) begin
            glitch(1'b0, w, 4, "R3");
            glitch(1'b1, w, 4, "R3");
        end
        glitch(1'b0, 5, 4, "R4");
        glitch(1'b1, 5, 4, "R4");
        glitch(1'b0, 9, 4, "R4");

        // R6: spacing changes mid-stream
        for (int i = 0; i < 20; i++) step(i[2], 4, "R6");
        for (int i = 0; i < 20; i++) step(i[1], 6, "R6");
        for (int i = 0; i < 12; i++) step(i[0], 2, "R6");

        // R7: setting 0 behaves as spacing 1
        glitch(1'b0, 1, 0, "R7");
        glitch(1'b0, 2, 0, "R7");
        glitch(1'b1, 1, 0, "R7");

        // R8: widest spacing
        glitch(1'b0, 15, 15, "R8");
        glitch(1'b1, 15, 15, "R8");
        glitch(1'b0, 16, 15, "R8");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule